// File: doc/BRIEF.md
# Serial Flash Sector-Erase Command Controller

This block is the device-side command logic of a serial flash, limited to the sector-erase path. It listens on a mode-0 SPI link: the clock idles low, data is captured on the rising clock edge, and read data changes on the falling edge. All three SPI inputs pass through a synchroniser into the system clock domain. The block recognises three commands: write-enable, read-status and sector-erase. It keeps a write-enable latch and a busy flag.

A sector erase is committed only when chip select is released right after the 32nd bit, the latch is set, the device is idle and the addressed sector is not protected. The block then emits a one-cycle pulse carrying the sector index and holds busy for a fixed number of system clocks. The latch clears just before the cycle ends. The memory array sits outside: it consumes the pulse and the sector index. An active-low reset aborts a running cycle. After reset, chip select is ignored for a recovery period.

Top module: `sector_erase_ctrl`

## Requirements
- R1: While reset is low and right after it, busy, erase_pulse and spi_miso are 0, and a status read returns 8'h00.
- R2: A write-enable frame sets the latch. Such a frame is opcode 8'h06 followed by chip-select release after exactly 8 bits; any other bit count leaves the latch unchanged. A read-status frame (opcode 8'h05) returns {6'b0, latch in bit 1, busy in bit 0} MSB first. These bits change on falling SCK and are sampled by the host on rising SCK.
- R3: A sector-erase frame is opcode 8'hD8 plus a 24-bit address, both sent MSB first. It is accepted when chip select rises after exactly 32 bits with the latch set. The block then raises erase_pulse for one cycle, with erase_sector equal to address bits 19:16. Address bits 23:20 do not affect the result.
- R4: When chip select rises after any bit count other than 32 (for example 31 or 40), no erase starts and the latch is kept.
- R5: A sector erase issued with the latch clear produces no pulse and no busy.
- R6: A sector erase whose sector has its bit set in protect_mask (bit index = sector index) is not executed, and the latch stays set.
- R7: busy is high for exactly ERASE_CYCLES system clocks, starting in the cycle of erase_pulse. The status busy bit reads 1 during that window.
- R8: The latch remains set at the start of an erase. It clears one cycle before busy falls, so it reads 0 after completion.
- R9: While busy, erase and write-enable frames are ignored and the running cycle keeps its length.
- R10: A read-status frame is served while busy.
- R11: Driving rst_n low drops busy at once, without any further pulse, and clears the latch. A chip-select fall within RECOVER_CYCLES clocks after reset release starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts an erase |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host, 0 when not reading |
| protect_mask | input | SECTORS | Per-sector protection, 1 = protected |
| busy | output | 1 | Erase cycle running |
| erase_pulse | output | 1 | One-cycle request to the array to erase a sector |
| erase_sector | output | log2(SECTORS) | Sector index, valid with erase_pulse |

## Verification
The erase command is driven at 31, 32 and 40 bits to separate the commit-on-boundary rule from a plain count threshold. Erases are also issued with and without a prior write-enable, and to a protected and an unprotected sector, to show that each gate acts on its own. An address with nonzero bits 23:20 shows that only bits 19:16 pick the sector. Status reads of 8'h02 versus 8'h03 versus 8'h00 at chosen points tell the latch apart from busy and confirm MSB-first order. A reset in mid-erase, followed by a frame inside the recovery window, exercises abort and lockout.

// File: rtl/se_pkg.sv
package se_pkg;
    localparam int CMD_BITS = 32;
    localparam int CNT_W    = 6;

    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_ERASE = 8'hD8;

    typedef struct packed {
        logic                active;
        logic [CNT_W-1:0]    bits;
        logic [CMD_BITS-1:0] sh;
        logic                rd;
        logic [7:0]          out;
        logic [2:0]          obit;
        logic                miso;
    } frame_t;
endpackage

// File: rtl/se_sync.sv
module se_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic mosi_s
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES:0]   cs;
        logic [STAGES-1:0] mosi;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sck  = {q.sck[STAGES-1:0], sck_i};
        d.cs   = {q.cs[STAGES-1:0], cs_n_i};
        if (STAGES > 1) begin
            d.mosi = {q.mosi[STAGES-2:0], mosi_i};
        end else begin
            d.mosi = {STAGES{mosi_i}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck  <= '0;
            q.cs   <= '1;
            q.mosi <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = q.sck[STAGES-1] & ~q.sck[STAGES];
    assign sck_fall = ~q.sck[STAGES-1] & q.sck[STAGES];
    assign cs_rise  = q.cs[STAGES-1] & ~q.cs[STAGES];
    assign cs_fall  = ~q.cs[STAGES-1] & q.cs[STAGES];
    assign mosi_s   = q.mosi[STAGES-1];
endmodule

// File: rtl/se_frame.sv
module se_frame
    import se_pkg::*;
#(
    parameter int SECTOR_BITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sck_rise,
    input  logic                   sck_fall,
    input  logic                   cs_rise,
    input  logic                   cs_fall,
    input  logic                   mosi_s,
    input  logic                   locked,
    input  logic [7:0]             status,
    output logic                   miso,
    output logic                   end_valid,
    output logic                   end_wren,
    output logic                   end_erase,
    output logic [SECTOR_BITS-1:0] end_sector
);
    frame_t q, d;

    always_comb begin
        d = q;
        if (cs_rise) begin
            d.active = 1'b0;
            d.rd     = 1'b0;
            d.miso   = 1'b0;
        end else if (cs_fall) begin
            if (!locked) begin
                d.active = 1'b1;
                d.bits   = '0;
                d.sh     = '0;
                d.rd     = 1'b0;
                d.obit   = '0;
            end
        end else if (q.active) begin
            if (sck_rise) begin
                d.sh = {q.sh[CMD_BITS-2:0], mosi_s};
                if (q.bits != '1) begin
                    d.bits = q.bits + 1'b1;
                end
                if (q.bits == CNT_W'(7) && d.sh[7:0] == OPC_RDSR) begin
                    d.rd   = 1'b1;
                    d.out  = status;
                    d.obit = '0;
                end
            end
            if (sck_fall && q.rd) begin
                d.miso = q.out[7];
                d.out  = (q.obit == 3'd7) ? status : {q.out[6:0], 1'b0};
                d.obit = q.obit + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign miso       = q.miso;
    assign end_valid  = cs_rise & q.active;
    assign end_wren   = (q.bits == CNT_W'(8)) && (q.sh[7:0] == OPC_WREN);
    assign end_erase  = (q.bits == CNT_W'(CMD_BITS)) && (q.sh[CMD_BITS-1 -: 8] == OPC_ERASE);
    assign end_sector = q.sh[16 +: SECTOR_BITS];

    // R11: no frame may open while the post-reset lockout is running
    a_r11_no_frame_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !q.active) |=> !q.active);

    // R2: status line stays low unless a status read is in progress
    a_r2_miso_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd |-> !q.miso);
endmodule

// File: rtl/se_seq.sv
module se_seq #(
    parameter int SECTORS        = 16,
    parameter int ERASE_CYCLES   = 2000,
    parameter int RECOVER_CYCLES = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       end_valid,
    input  logic                       end_wren,
    input  logic                       end_erase,
    input  logic [$clog2(SECTORS)-1:0] end_sector,
    input  logic [SECTORS-1:0]         protect_mask,
    output logic                       locked,
    output logic [7:0]                 status,
    output logic                       busy,
    output logic                       erase_pulse,
    output logic [$clog2(SECTORS)-1:0] erase_sector
);
    localparam int SB = $clog2(SECTORS);
    localparam int TW = $clog2(ERASE_CYCLES + 1);
    localparam int LW = $clog2(RECOVER_CYCLES + 1);

    typedef struct packed {
        logic          wel;
        logic          busy;
        logic [TW-1:0] timer;
        logic [LW-1:0] lock;
        logic          pulse;
        logic [SB-1:0] sector;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (q.lock != '0) begin
            d.lock = q.lock - 1'b1;
        end
        if (q.busy) begin
            if (q.timer == '0) begin
                d.busy = 1'b0;
            end else begin
                d.timer = q.timer - 1'b1;
                if (q.timer == TW'(1)) begin
                    d.wel = 1'b0;
                end
            end
        end
        if (end_valid && !q.busy) begin
            if (end_wren) begin
                d.wel = 1'b1;
            end else if (end_erase && q.wel && !protect_mask[end_sector]) begin
                d.busy   = 1'b1;
                d.timer  = TW'(ERASE_CYCLES - 1);
                d.pulse  = 1'b1;
                d.sector = end_sector;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.wel    <= 1'b0;
            q.busy   <= 1'b0;
            q.timer  <= '0;
            q.lock   <= LW'(RECOVER_CYCLES);
            q.pulse  <= 1'b0;
            q.sector <= '0;
        end else begin
            q <= d;
        end
    end

    assign locked       = (q.lock != '0);
    assign status       = {6'b0, q.wel, q.busy};
    assign busy         = q.busy;
    assign erase_pulse  = q.pulse;
    assign erase_sector = q.sector;

    // R3: the erase request lasts one cycle
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |=> !q.pulse);

    // R5: a request needs the latch to have been set before
    a_r5_pulse_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> $past(q.wel));

    // R6: never request a protected sector
    a_r6_no_protected_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.pulse |-> (($past(protect_mask) & (SECTORS'(1) << q.sector)) == '0));

    // R7: the cycle counter steps down by one while busy
    a_r7_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.timer != '0) |=> (q.busy && q.timer == TW'($past(q.timer) - TW'(1))));

    // R8: the latch is already clear when busy ends
    a_r8_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);

    // R9: no new request while a cycle is running
    a_r9_no_pulse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.timer != '0) |=> !q.pulse);
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl #(
    parameter int SECTORS        = 16,
    parameter int ERASE_CYCLES   = 2000,
    parameter int RECOVER_CYCLES = 40,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [SECTORS-1:0]         protect_mask,
    output logic                       busy,
    output logic                       erase_pulse,
    output logic [$clog2(SECTORS)-1:0] erase_sector
);
    localparam int SECTOR_BITS = $clog2(SECTORS);

    logic                   sck_rise, sck_fall, cs_rise, cs_fall, mosi_s;
    logic                   locked;
    logic [7:0]             status;
    logic                   end_valid, end_wren, end_erase;
    logic [SECTOR_BITS-1:0] end_sector;

    se_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_i    (spi_sck),
        .cs_n_i   (spi_cs_n),
        .mosi_i   (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .mosi_s   (mosi_s)
    );

    se_frame #(.SECTOR_BITS(SECTOR_BITS)) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .cs_rise    (cs_rise),
        .cs_fall    (cs_fall),
        .mosi_s     (mosi_s),
        .locked     (locked),
        .status     (status),
        .miso       (spi_miso),
        .end_valid  (end_valid),
        .end_wren   (end_wren),
        .end_erase  (end_erase),
        .end_sector (end_sector)
    );

    se_seq #(
        .SECTORS        (SECTORS),
        .ERASE_CYCLES   (ERASE_CYCLES),
        .RECOVER_CYCLES (RECOVER_CYCLES)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .end_valid    (end_valid),
        .end_wren     (end_wren),
        .end_erase    (end_erase),
        .end_sector   (end_sector),
        .protect_mask (protect_mask),
        .locked       (locked),
        .status       (status),
        .busy         (busy),
        .erase_pulse  (erase_pulse),
        .erase_sector (erase_sector)
    );
endmodule

// File: tb/sector_erase_ctrl_tb.sv
module sector_erase_ctrl_tb_top;
    localparam int CLK_PERIOD  = 10;
    localparam int HALF        = 8;
    localparam int ERASE_CYC   = 2000;
    localparam int RECOVER_CYC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [15:0] prot = '0;
    logic        miso, busy, pulse;
    logic [3:0]  sector;

    sector_erase_ctrl #(
        .SECTORS(16), .ERASE_CYCLES(ERASE_CYC), .RECOVER_CYCLES(RECOVER_CYC), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .protect_mask(prot), .busy(busy), .erase_pulse(pulse),
        .erase_sector(sector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc = 0, commit_at = -1, wel_at = -1, busy_left = 0, rel_cyc = 0;
    int busy_seen = 0, pulse_count = 0;
    bit m_wel = 0, exp_pulse = 0;
    logic [3:0] exp_sector = '0, pend_sector = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model stepped each clock, compared a quarter period later
    always begin
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            busy_left = 0; m_wel = 0; commit_at = -1; wel_at = -1;
            exp_pulse = 0; rel_cyc = cyc;
        end else begin
            exp_pulse = 0;
            if (cyc == commit_at) begin
                busy_left = ERASE_CYC; exp_pulse = 1; exp_sector = pend_sector;
            end else if (busy_left > 0) begin
                busy_left--;
            end
            if (busy_left == 1) m_wel = 0;
            if (cyc == wel_at) m_wel = 1;
        end
        #(CLK_PERIOD/4);
        if (busy === 1'b1) busy_seen++;
        if (pulse === 1'b1) pulse_count++;
        check(busy === (busy_left > 0), "R7 busy window", int'(busy), int'(busy_left > 0));
        check(pulse === exp_pulse, "R3 erase pulse", int'(pulse), int'(exp_pulse));
        if (exp_pulse)
            check(sector === exp_sector, "R3 erase sector", int'(sector), int'(exp_sector));
    end

    task automatic frame(input logic [39:0] data, input int nbits, output logic [7:0] rx);
        bit locked_f, busy_f;
        @(negedge clk);
        cs_n = 1'b0;
        locked_f = (cyc - rel_cyc) < RECOVER_CYC + 5;
        repeat (HALF) @(negedge clk);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            mosi = data[39-i];
            repeat (HALF) @(negedge clk);
            rx = {rx[6:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
        busy_f = busy_left > 0;
        if (!locked_f && !busy_f) begin
            if (nbits == 8 && data[39:32] == 8'h06) begin
                wel_at = cyc + 3;
            end else if (nbits == 32 && data[39:32] == 8'hD8 && m_wel && !prot[data[27:24]]) begin
                commit_at = cyc + 3;
                pend_sector = data[27:24];
            end
        end
        cs_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic read_status(input int exp, input string tag);
        logic [7:0] rx;
        frame({8'h05, 32'h0}, 16, rx);
        check(rx == exp[7:0], tag, int'(rx), exp);
    endtask

    task automatic send(input logic [39:0] data, input int nbits);
        logic [7:0] rx;
        frame(data, nbits, rx);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(busy === 1'b0, "R1 busy in reset", int'(busy), 0);
        check(pulse === 1'b0, "R1 pulse in reset", int'(pulse), 0);
        check(miso === 1'b0, "R1 miso in reset", int'(miso), 0);
        rst_n = 1'b1;
        send({8'h06, 32'h0}, 8);
        repeat (RECOVER_CYC) @(negedge clk);
        read_status(0, "R11 frame in lockout ignored, R1 status");
        send({8'h06, 32'h0}, 9);
        read_status(0, "R2 write-enable of 9 bits ignored");
        send({8'h06, 32'h0}, 8);
        read_status(2, "R2 write-enable sets latch");
        send({8'hD8, 24'h012345, 8'h0}, 31);
        read_status(2, "R4 erase at 31 bits discarded");
        send({8'hD8, 24'h012345, 8'hA5}, 40);
        read_status(2, "R4 erase at 40 bits discarded");
        prot = 16'h0020;
        send({8'hD8, 24'hF51234, 8'h0}, 32);
        read_status(2, "R6 protected sector not erased");
        check(pulse_count == 0, "R4 R6 no pulse yet", pulse_count, 0);
        busy_seen = 0;
        send({8'hD8, 24'hA30000, 8'h0}, 32);
        read_status(3, "R10 status read while busy, R8 latch still set");
        send({8'h06, 32'h0}, 8);
        send({8'hD8, 24'h070000, 8'h0}, 32);
        while (busy_left > 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(busy_seen == ERASE_CYC, "R7 busy length", busy_seen, ERASE_CYC);
        check(pulse_count == 1, "R9 erase during busy ignored", pulse_count, 1);
        read_status(0, "R8 latch cleared, R9 write-enable during busy ignored");
        send({8'hD8, 24'h020000, 8'h0}, 32);
        read_status(0, "R5 erase without latch ignored");
        check(pulse_count == 1, "R5 no pulse without latch", pulse_count, 1);
        send({8'h06, 32'h0}, 8);
        send({8'hD8, 24'h0FFFFF, 8'h0}, 32);
        repeat (100) @(negedge clk);
        check(busy === 1'b1, "R3 erase of sector 15 running", int'(busy), 1);
        rst_n = 1'b0;
        #1;
        check(busy === 1'b0, "R11 reset aborts erase", int'(busy), 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        send({8'h06, 32'h0}, 8);
        repeat (RECOVER_CYC) @(negedge clk);
        read_status(0, "R11 latch cleared and lockout after reset");
        check(pulse_count == 2, "R11 no pulse after abort", pulse_count, 2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired before end of test");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule